// File: doc/BRIEF.md
# Clock-Controlled LFSR Keystream Generator

This block produces a pseudo-random keystream from two 7-stage linear feedback shift registers. The first one, the control register, advances by exactly one position on every enabled clock. Its current output bit decides how far the second one, the data register, moves in the same clock: one position when the bit is 0, two positions when it is 1. Both positions are computed combinationally, so one keystream bit comes out on every enabled clock. The keystream bit is the data register's output bit. A plain XOR stage combines it with a serial data input.

Encryption and decryption use the same block. A receiver seeded with the same two values and enabled on the same clocks regenerates the same keystream, and XOR with the ciphertext returns the plaintext. Seeds are loaded through a load strobe. An all-zero seed would lock a register, so the block replaces it with the single-one value. With both registers maximal-length, the keystream period reaches 127 × 127 = 16129 bits.

Top module: `ccks_gen`

## Requirements
- R1: While `rst_ni` is low, and until the first load or enabled clock after it rises, both registers hold 7'b0000001. `ks_o` is therefore 1.
- R2: On a clock with `en_i` high and `load_i` low, the control register moves one position: next = {q[0]^q[1], q[6:1]}. Its output bit is q[0].
- R3: On the same kind of clock, the data register uses the update d' = {d[0]^d[4], d[6:1]}. It applies the update once when the control bit q[0] held before that edge is 0, and twice when that bit is 1.
- R4: `ks_o` is the data register's current bit 0, and `dout_o` equals `din_i` XOR `ks_o`. Both follow their inputs with no clock delay.
- R5: A clock with `load_i` high copies `ctrl_seed_i` into the control register and `data_seed_i` into the data register. This happens whatever `en_i` is: load has priority over advancing.
- R6: A loaded seed of 7'b0000000 is stored as 7'b0000001, so neither register ever holds zero.
- R7: On a clock with `load_i` and `en_i` both low, both registers keep their state, and `ks_o` does not change.
- R8: After any nonzero seeds are loaded and the block is then enabled on every clock, the keystream repeats with a period of 16129 bits.
- R9: A second instance with the same seeds, load and enable, fed with the first instance's `dout_o`, outputs the original `din_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Seed load strobe; takes priority over enable |
| ctrl_seed_i | input | 7 | Seed for the control register |
| data_seed_i | input | 7 | Seed for the data register |
| en_i | input | 1 | Advance both registers this clock |
| din_i | input | 1 | Serial data bit to combine |
| ks_o | output | 1 | Current keystream bit |
| dout_o | output | 1 | din_i XOR ks_o |

## Verification
Seed loading and keystream advance can be requested in the same clock, and load must win in both registers. The random phase draws `load_i` and `en_i` independently, so the two often coincide. A directed step also asserts both together with an all-zero control seed. Each time, the bench model applies load-first priority, and the keystream seen on the following cycles shows whether either register stepped instead of loading.

// File: rtl/ccks_pkg.sv
package ccks_pkg;
  localparam int unsigned LFSR_W = 7;
  typedef logic [LFSR_W-1:0] lfsr_t;

  // Feedback tap masks (bit i set = stage i feeds the XOR)
  localparam lfsr_t CTRL_TAPS_DEF = 7'b0000011;
  localparam lfsr_t DATA_TAPS_DEF = 7'b0010001;
  localparam lfsr_t ONE_SEED      = lfsr_t'(1);

  // One right-shift step; new bit enters at the top, output is bit 0
  function automatic lfsr_t lfsr_adv(lfsr_t s, lfsr_t taps);
    return {^(s & taps), s[LFSR_W-1:1]};
  endfunction

  // Lock-up guard for seeds
  function automatic lfsr_t seed_fix(lfsr_t s);
    return (s == '0) ? ONE_SEED : s;
  endfunction
endpackage

// File: rtl/ccks_lfsr.sv
module ccks_lfsr
  import ccks_pkg::*;
#(
  parameter lfsr_t TAPS = CTRL_TAPS_DEF
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  lfsr_t seed_i,
  input  logic  adv_i,
  input  logic  two_i,
  output lfsr_t q_o
);
  lfsr_t state_q;
  lfsr_t one_step;
  lfsr_t two_step;
  lfsr_t next_state;

  assign one_step = lfsr_adv(state_q, TAPS);
  assign two_step = lfsr_adv(one_step, TAPS);

  always_comb begin
    next_state = state_q;
    if (load_i)      next_state = seed_fix(seed_i);
    else if (adv_i)  next_state = two_i ? two_step : one_step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ONE_SEED;
    else         state_q <= next_state;
  end

  assign q_o = state_q;
endmodule

// File: rtl/ccks_mix.sv
module ccks_mix (
  input  logic ks_i,
  input  logic din_i,
  output logic dout_o
);
  assign dout_o = din_i ^ ks_i;
endmodule

// File: rtl/ccks_gen.sv
module ccks_gen
  import ccks_pkg::*;
#(
  parameter lfsr_t CTRL_TAPS = CTRL_TAPS_DEF,
  parameter lfsr_t DATA_TAPS = DATA_TAPS_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [LFSR_W-1:0]   ctrl_seed_i,
  input  logic [LFSR_W-1:0]   data_seed_i,
  input  logic                en_i,
  input  logic                din_i,
  output logic                ks_o,
  output logic                dout_o
);
  // Named internal events for the checker
  lfsr_t ctrl_q;
  lfsr_t data_q;
  logic  ctrl_bit;

  assign ctrl_bit = ctrl_q[0];

  ccks_lfsr #(.TAPS(CTRL_TAPS)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .seed_i (ctrl_seed_i),
    .adv_i  (en_i),
    .two_i  (1'b0),
    .q_o    (ctrl_q)
  );

  ccks_lfsr #(.TAPS(DATA_TAPS)) u_data (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .seed_i (data_seed_i),
    .adv_i  (en_i),
    .two_i  (ctrl_bit),
    .q_o    (data_q)
  );

  assign ks_o = data_q[0];

  ccks_mix u_mix (
    .ks_i   (ks_o),
    .din_i  (din_i),
    .dout_o (dout_o)
  );
endmodule

// File: rtl/ccks_gen_chk.sv
module ccks_gen_chk
  import ccks_pkg::*;
#(
  parameter lfsr_t CTRL_TAPS = CTRL_TAPS_DEF,
  parameter lfsr_t DATA_TAPS = DATA_TAPS_DEF
) (
  input logic  clk_i,
  input logic  rst_ni,
  input logic  load_i,
  input logic  en_i,
  input lfsr_t ctrl_seed_i,
  input lfsr_t data_seed_i,
  input lfsr_t ctrl_q,
  input lfsr_t data_q,
  input logic  ctrl_bit
);
  a_r2_ctrl_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> ctrl_q == lfsr_adv($past(ctrl_q), CTRL_TAPS));

  a_r3_data_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && !ctrl_bit) |=> data_q == lfsr_adv($past(data_q), DATA_TAPS));

  a_r3_data_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && ctrl_bit) |=>
      data_q == lfsr_adv(lfsr_adv($past(data_q), DATA_TAPS), DATA_TAPS));

  a_r5_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ctrl_q == seed_fix($past(ctrl_seed_i))) &&
               (data_q == seed_fix($past(data_seed_i))));

  a_r6_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q != '0) && (data_q != '0));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !en_i) |=> $stable(ctrl_q) && $stable(data_q));
endmodule

bind ccks_gen ccks_gen_chk #(.CTRL_TAPS(CTRL_TAPS), .DATA_TAPS(DATA_TAPS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .en_i        (en_i),
  .ctrl_seed_i (ctrl_seed_i),
  .data_seed_i (data_seed_i),
  .ctrl_q      (ctrl_q),
  .data_q      (data_q),
  .ctrl_bit    (ctrl_bit)
);

// File: tb/ccks_gen_tb_top.sv
`timescale 1ns/1ps
module ccks_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [6:0] cseed = '0;
  logic [6:0] dseed = '0;
  logic       en = 1'b0;
  logic       din = 1'b0;
  logic       ks, dout, rx_ks, rx_dout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [6:0] mc, md;   // bench model state
  logic       hist [0:63];

  always #2 clk = ~clk;  // 250 MHz

  ccks_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .ctrl_seed_i(cseed),
    .data_seed_i(dseed), .en_i(en), .din_i(din), .ks_o(ks), .dout_o(dout)
  );

  ccks_gen rx_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .ctrl_seed_i(cseed),
    .data_seed_i(dseed), .en_i(en), .din_i(dout), .ks_o(rx_ks), .dout_o(rx_dout)
  );

  // Bench restatement of the register updates
  function automatic logic [6:0] m_ctrl(logic [6:0] s);
    logic fb;
    fb = s[1] ^ s[0];
    return {fb, s[6:1]};
  endfunction

  function automatic logic [6:0] m_data(logic [6:0] s);
    logic fb;
    fb = s[4] ^ s[0];
    return {fb, s[6:1]};
  endfunction

  function automatic logic [6:0] m_seed(logic [6:0] s);
    return (s == 7'd0) ? 7'd1 : s;
  endfunction

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One clock: drive after negedge, check combinational outputs, update model
  task automatic cycle(input logic ld, input logic [6:0] cs, input logic [6:0] ds,
                       input logic e, input logic d);
    @(negedge clk);
    load = ld; cseed = cs; dseed = ds; en = e; din = d;
    #1;
    chk("R3 ks", {6'd0, ks}, {6'd0, md[0]});
    chk("R4 dout", {6'd0, dout}, {6'd0, d ^ md[0]});
    chk("R9 decrypt", {6'd0, rx_dout}, {6'd0, d});
    if (ld) begin
      mc = m_seed(cs);
      md = m_seed(ds);
    end else if (e) begin
      if (mc[0]) md = m_data(m_data(md));
      else       md = m_data(md);
      mc = m_ctrl(mc);
    end
  endtask

  initial begin
    mc = 7'd1; md = 7'd1;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ks", {6'd0, ks}, 7'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 after release ks", {6'd0, ks}, 7'd1);

    // R2/R3 from reset state, plain enabled run
    repeat (40) cycle(1'b0, 7'd0, 7'd0, 1'b1, 1'($urandom));

    // R6: zero seeds on both, then run
    cycle(1'b1, 7'd0, 7'd0, 1'b0, 1'b0);
    repeat (20) cycle(1'b0, 7'd0, 7'd0, 1'b1, 1'($urandom));

    // R5: load and enable together, zero control seed
    cycle(1'b1, 7'd0, 7'b1011010, 1'b1, 1'b1);
    repeat (20) cycle(1'b0, 7'd0, 7'd0, 1'b1, 1'($urandom));

    // R7: hold with enable low; ks must stay put
    begin
      logic held;
      held = md[0];
      repeat (10) begin
        cycle(1'b0, 7'($urandom), 7'($urandom), 1'b0, 1'($urandom));
        chk("R7 hold", {6'd0, ks}, {6'd0, held});
      end
    end

    // Random mix of load, enable and data
    for (int i = 0; i < 3000; i++) begin
      logic r_ld, r_en;
      r_ld = (($urandom % 16) == 0);
      r_en = (($urandom % 4) != 0);
      cycle(r_ld, 7'($urandom), 7'($urandom), r_en, 1'($urandom));
    end

    // R8: period 16129 with continuous enable
    cycle(1'b1, 7'b0110001, 7'b1000000, 1'b0, 1'b0);
    for (int i = 0; i < 64; i++) begin
      cycle(1'b0, 7'd0, 7'd0, 1'b1, 1'b0);
      hist[i] = ks;
    end
    repeat (16129 - 64) cycle(1'b0, 7'd0, 7'd0, 1'b1, 1'b0);
    for (int i = 0; i < 64; i++) begin
      cycle(1'b0, 7'd0, 7'd0, 1'b1, 1'b0);
      chk("R8 period", {6'd0, ks}, {6'd0, hist[i]});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule